// File: doc/BRIEF.md
# Signed Sequential Divider with Sign Correction

This block divides one two's-complement integer by another and returns a signed quotient and a signed remainder. It takes the magnitude of each operand and feeds both into an unsigned restoring shift-subtract core that settles one quotient bit per clock. A final stage then restores the signs. The quotient truncates toward zero. The remainder carries the sign of the dividend, so the dividend always equals quotient times divisor plus remainder.

A caller pulses `start` with both operands valid while `busy` is low. `done` then rises for one cycle, and the results are valid from that cycle until the next result replaces them. Two operand pairs are settled at once without running the core. The first is a zero divisor. The second is the most negative value divided by minus one, whose true quotient is one larger than the largest positive value.

Top module: `signed_divider`

## Requirements
- R1: After reset, busy, done, quotient, remainder, div_by_zero and overflow are all 0.
- R2: For a nonzero divisor and no overflow, the magnitude of the quotient is the magnitude of the dividend divided by the magnitude of the divisor, truncated toward zero.
- R3: The quotient is negative (two's complement) exactly when one operand is negative and the quotient magnitude is nonzero.
- R4: The remainder is zero or has the sign of the dividend, its magnitude is smaller than that of the divisor, and dividend = quotient*divisor + remainder.
- R5: A zero divisor sets div_by_zero, makes the quotient all ones and the remainder equal to the dividend, and raises done in the cycle right after the start edge, with busy staying low.
- R6: The most negative dividend divided by -1 sets overflow, makes the quotient the most negative value and the remainder 0, and raises done in the cycle right after the start edge, with busy staying low.
- R7: For an ordinary division, busy is high from the cycle after the start edge for WIDTH+1 cycles (WIDTH core steps and one sign-fix cycle). done is high in the cycle that follows.
- R8: done is high for exactly one cycle, and busy is low whenever done is high.
- R9: A start that comes while busy is high is ignored. The running division completes with its original operands, and no second result follows.
- R10: Results and flags hold their values until the next completion. Both flags are low for an ordinary division, and a start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division using the present operands |
| dividend | input | WIDTH | Signed dividend |
| divisor | input | WIDTH | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are new |
| quotient | output | WIDTH | Signed quotient |
| remainder | output | WIDTH | Signed remainder |
| div_by_zero | output | 1 | Last result had a zero divisor |
| overflow | output | 1 | Last result was most-negative divided by -1 |

## Verification
Two things can meet in one cycle: the completion pulse of one division and the start of the next. The bench drives a new start in the very cycle where done is high and expects it to be accepted, so busy rises on the next cycle while the first result stays visible. It also pulses start in the middle of a running division and expects that pulse to leave no trace. A behavioural reference model, built from integer division and modulo, predicts busy, done and every output on each clock, and any mismatch in either collision is reported against the requirement concerned.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg_a,
    output logic             neg_b,
    output logic             zero_div,
    output logic             min_by_m1
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    always_comb begin
        neg_a     = dividend[WIDTH-1];
        neg_b     = divisor[WIDTH-1];
        // magnitude of the most negative value still fits as unsigned
        mag_a     = neg_a ? (~dividend + 1'b1) : dividend;
        mag_b     = neg_b ? (~divisor + 1'b1) : divisor;
        zero_div  = (divisor == '0);
        min_by_m1 = (dividend == MOST_NEG) && (divisor == ALL_ONES);
    end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] mag_a,
    input  logic [WIDTH-1:0] mag_b,
    output logic [WIDTH-1:0] uquo,
    output logic [WIDTH-1:0] urem
);
    typedef struct packed {
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dvs;
    } core_t;

    core_t core_d, core_q;
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] trial;

    always_comb begin
        core_d  = core_q;
        shifted = {core_q.rem, core_q.quo[WIDTH-1]};
        trial   = shifted - {1'b0, core_q.dvs};
        if (load) begin
            core_d.rem = '0;
            core_d.quo = mag_a;
            core_d.dvs = mag_b;
        end else if (step) begin
            if (!trial[WIDTH]) begin
                core_d.rem = trial[WIDTH-1:0];
                core_d.quo = {core_q.quo[WIDTH-2:0], 1'b1};
            end else begin
                core_d.rem = shifted[WIDTH-1:0];
                core_d.quo = {core_q.quo[WIDTH-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign uquo = core_q.quo;
    assign urem = core_q.rem;

    // R4: partial remainder stays below the divisor magnitude after every step
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (core_q.rem < core_q.dvs));
endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] uquo,
    input  logic [WIDTH-1:0] urem,
    input  logic             flip_quo,
    input  logic             flip_rem,
    output logic [WIDTH-1:0] squo,
    output logic [WIDTH-1:0] srem
);
    always_comb begin
        squo = flip_quo ? (~uquo + 1'b1) : uquo;
        srem = flip_rem ? (~urem + 1'b1) : urem;
    end
endmodule

// File: rtl/signed_divider.sv
module signed_divider
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_by_zero,
    output logic             overflow
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [CW-1:0]    LAST_CNT = CW'(WIDTH - 1);

    typedef struct packed {
        sdiv_state_e      st;
        logic [CW-1:0]    cnt;
        logic             flip_quo;
        logic             flip_rem;
        logic             done;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] rem;
        logic             dz;
        logic             ov;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WIDTH-1:0] mag_a, mag_b, uquo, urem, squo, srem;
    logic             neg_a, neg_b, zero_div, min_by_m1;
    logic             accept, load, step;

    sdiv_prep #(.WIDTH(WIDTH)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_a    (neg_a),
        .neg_b    (neg_b),
        .zero_div (zero_div),
        .min_by_m1(min_by_m1)
    );

    sdiv_core #(.WIDTH(WIDTH)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .step (step),
        .mag_a(mag_a),
        .mag_b(mag_b),
        .uquo (uquo),
        .urem (urem)
    );

    sdiv_fix #(.WIDTH(WIDTH)) u_fix (
        .uquo    (uquo),
        .urem    (urem),
        .flip_quo(ctl_q.flip_quo),
        .flip_rem(ctl_q.flip_rem),
        .squo    (squo),
        .srem    (srem)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        accept     = start && (ctl_q.st == ST_IDLE);
        load       = 1'b0;
        step       = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (zero_div) begin
                        ctl_d.quo  = '1;
                        ctl_d.rem  = dividend;
                        ctl_d.dz   = 1'b1;
                        ctl_d.ov   = 1'b0;
                        ctl_d.done = 1'b1;
                    end else if (min_by_m1) begin
                        ctl_d.quo  = MOST_NEG;
                        ctl_d.rem  = '0;
                        ctl_d.dz   = 1'b0;
                        ctl_d.ov   = 1'b1;
                        ctl_d.done = 1'b1;
                    end else begin
                        load           = 1'b1;
                        ctl_d.st       = ST_RUN;
                        ctl_d.cnt      = LAST_CNT;
                        ctl_d.flip_quo = neg_a ^ neg_b;
                        ctl_d.flip_rem = neg_a;
                    end
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (ctl_q.cnt == '0) ctl_d.st = ST_FIX;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_FIX: begin
                ctl_d.quo  = squo;
                ctl_d.rem  = srem;
                ctl_d.dz   = 1'b0;
                ctl_d.ov   = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = ctl_q.done;
    assign quotient    = ctl_q.quo;
    assign remainder   = ctl_q.rem;
    assign div_by_zero = ctl_q.dz;
    assign overflow    = ctl_q.ov;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: never busy while reporting completion
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: busy only rises in answer to a start seen while idle
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && !$past(busy)));
    // R7: the sign-fix cycle always follows the core iterations
    p_fix_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FIX) |-> ($past(ctl_q.st) == ST_RUN));
    // R5: zero-divisor result shape
    p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> ((quotient == '1) && !overflow));
    // R6: overflow result shape
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> ((quotient == MOST_NEG) && (remainder == '0)));
    // R4: a nonzero remainder follows the sign of the dividend
    p_rem_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero && !overflow && (remainder != '0))
            |-> (remainder[WIDTH-1] == ctl_q.flip_rem));
endmodule

// File: tb/signed_divider_tb.sv
module signed_divider_tb;
    localparam int W = 16;
    localparam longint MINV = -(longint'(1) << (W-1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero, overflow;
    logic [W-1:0] quotient, remainder;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    bit           m_busy = 0, m_done = 0, m_dz = 0, m_ov = 0;
    bit           p_dz = 0, p_ov = 0;
    int           m_cnt = 0;
    logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
    string        m_tag = "R1", p_tag = "R1";

    signed_divider #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero), .overflow(overflow)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // expected result of one operation, from integer arithmetic
    task automatic predict(input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] q, output logic [W-1:0] r,
                           output bit dz, output bit ov, output bit special,
                           output string tag);
        longint sa, sb, lq, lr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        dz = 0; ov = 0; special = 0;
        if (sb == 0) begin
            q = '1; r = a; dz = 1; special = 1; tag = "R5";
        end else if (sa == MINV && sb == -1) begin
            q = MINV[W-1:0]; r = '0; ov = 1; special = 1; tag = "R6";
        end else begin
            lq = sa / sb;
            lr = sa % sb;
            q = lq[W-1:0];
            r = lr[W-1:0];
            tag = ((sa < 0) != (sb < 0)) ? "R3" : "R2";
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            m_q = '0; m_r = '0; m_dz = 0; m_ov = 0; m_tag = "R1";
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    m_q = p_q; m_r = p_r; m_dz = p_dz; m_ov = p_ov; m_tag = p_tag;
                end
            end else if (start) begin
                logic [W-1:0] q, r;
                bit dz, ov, sp;
                string tg;
                predict(dividend, divisor, q, r, dz, ov, sp, tg);
                if (sp) begin
                    m_done = 1; m_q = q; m_r = r; m_dz = dz; m_ov = ov; m_tag = tg;
                end else begin
                    m_busy = 1; m_cnt = W + 1;
                    p_q = q; p_r = r; p_dz = dz; p_ov = ov; p_tag = tg;
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == m_busy, "R7 busy", busy, m_busy);
            check(done == m_done, "R8 done", done, m_done);
            check(quotient == m_q, {m_tag, " quotient"},
                  longint'($signed(quotient)), longint'($signed(m_q)));
            check(remainder == m_r, "R4 remainder",
                  longint'($signed(remainder)), longint'($signed(m_r)));
            check(div_by_zero == m_dz, "R5 div_by_zero", div_by_zero, m_dz);
            check(overflow == m_ov, "R6 overflow", overflow, m_ov);
        end
    end

    task automatic launch(input longint a, input longint b);
        @(negedge clk);
        start = 1'b1; dividend = a[W-1:0]; divisor = b[W-1:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input longint a, input longint b);
        launch(a, b);
        repeat (W + 3) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1 control", {busy, done}, 0);
        check(quotient == '0 && remainder == '0, "R1 data", quotient, 0);
        check(!div_by_zero && !overflow, "R1 flags", {div_by_zero, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4 sign combinations
        run_op(100, 7);
        // R10: flags low after an ordinary division
        check(!div_by_zero && !overflow, "R10 flags", {div_by_zero, overflow}, 0);
        run_op(-100, 7);
        run_op(100, -7);
        run_op(-100, -7);
        run_op(3, 10);
        run_op(-3, 10);
        run_op(MINV, 1);
        run_op(MINV, 2);
        run_op(MINV, MINV);
        run_op(32767, -1);

        // R5: zero divisor, done right after the start edge
        launch(-1234, 0);
        check(done == 1'b1 && busy == 1'b0, "R5 timing", {done, busy}, 2);
        repeat (2) @(negedge clk);
        run_op(5000, 0);

        // R6: overflow, done right after the start edge
        launch(MINV, -1);
        check(done == 1'b1 && busy == 1'b0, "R6 timing", {done, busy}, 2);
        repeat (2) @(negedge clk);

        // R7: exact latency of an ordinary division
        launch(1000, 3);
        for (int i = 0; i < W + 1; i++) begin
            check(busy == 1'b1 && done == 1'b0, "R7 busy window", {busy, done}, 2);
            @(negedge clk);
        end
        check(done == 1'b1 && quotient == 16'd333, "R7 completion", quotient, 333);
        @(negedge clk);
        check(done == 1'b0, "R8 pulse width", done, 0);

        // R9: start while busy is ignored
        launch(-999, 10);
        repeat (4) @(negedge clk);
        launch(7, 7);
        while (!done) @(negedge clk);
        check($signed(quotient) == -99 && $signed(remainder) == -9, "R9 original operands",
              longint'($signed(quotient)), -99);
        repeat (W + 3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9 no second result", {done, busy}, 0);

        // R10: a start in the done cycle is accepted
        launch(50, 5);
        while (!done) @(negedge clk);
        start = 1'b1; dividend = 16'(-77); divisor = 16'd4;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && quotient == 16'd10, "R10 back-to-back", quotient, 10);
        repeat (W + 3) @(negedge clk);
        check($signed(quotient) == -19 && $signed(remainder) == -1, "R10 second result",
              longint'($signed(quotient)), -19);

        // mixed operands
        for (int k = 0; k < 150; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (k % 10 == 0) rb = '0;
            if (k % 7 == 0)  rb = W'($urandom_range(0, 9)) - W'(4);
            run_op(longint'($signed(ra)), longint'($signed(rb)));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule